// File: doc/BRIEF.md
# Byte-Lane Static Memory with Asynchronous-Style Pins

This block models a word-wide static memory behind the pin set of a classic asynchronous SRAM. The pins are an address, active-low chip select, write enable and output enable, and one active-low enable for each byte lane. Everything is sampled on a fast simulation clock, so pin-level access and turn-around delays appear as whole clock cycles.

Instead of a bidirectional bus, the data path has three parts: a write-data input, a registered read-data output, and one drive-enable bit per byte lane. A surrounding pad ring or bus model combines them into a tri-state bus. Each lane is read, written and driven on its own. Drivers stay off while the chip is deselected or a write pulse is low. After a write pulse they wait a fixed number of cycles before they turn on again.

`ADDR_W` sets the depth to 2^ADDR_W words. Set `ADDR_W` to 16 to get the full 65,536 x 16 array. The default is smaller so the block elaborates quickly.

Top module: `sram_bytelane`

## Requirements
- R1: Storage holds 2^ADDR_W words of 16 bits. A lane of a location that has not been written since reset reads back as zero.
- R2: While chip select is high, both lane enables are 0 from the next cycle on, and no lane is written, whatever the other pins do.
- R3: With chip select low, write enable high and output enable low, lane enable bit 0 (data bits 7:0) is 1 exactly when the low byte enable is low. Lane enable bit 1 (data bits 15:8) is 1 exactly when the high byte enable is low. In both cases the bit is set one cycle after the pins are sampled. data_o carries the stored word from the same cycle.
- R4: A lane is written only while chip select, write enable and that lane's byte enable are all low. A lane whose byte enable is high keeps its old contents. With both byte enables high, nothing is written.
- R5: The value stored is the data and address present in the last sampled cycle of the overlap. The store takes effect at the first clock edge where the overlap is no longer present, whether the write pulse or the chip select ends the overlap.
- R6: With the chip selected, both lane enables are 0 if output enable is high (with write enable high) or if both byte enables are high.
- R7: While write enable is low, both lane enables are 0 one cycle later. After write enable returns high, the lane enables stay 0 for TURN_ON further sampled cycles (default 2). TURN_ON must be at least 1.
- R8: During and after an asynchronous reset (rst_ni low), lane_oe_o and data_o are zero. The drive hold-off also restarts at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Simulation clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| ub_ni | input | 1 | Upper byte (15:8) enable, active low |
| lb_ni | input | 1 | Lower byte (7:0) enable, active low |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data (registered) |
| lane_oe_o | output | 2 | Per-lane drive enable: bit 1 upper, bit 0 lower |

## Verification
Read pins affect lane_oe_o and data_o at the first edge that samples them, provided the hold-off counter is already zero. A write becomes visible to a read that is sampled at the edge after the commit edge. The bench drives pins on falling edges and samples one time unit after rising edges. Every read task holds its pins for three edges before it checks, which covers the two-cycle hold-off that follows any write. The turn-on test counts edges one at a time after the rising edge of write enable: the enables must be low after the first and second edges and high after the third.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = BYTE_W * LANES;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/sram_decode.sv
module sram_decode
  import sram_pkg::*;
(
  input  logic       cs_ni,
  input  logic       we_ni,
  input  logic       oe_ni,
  input  lane_mask_t be_ni,
  output lane_mask_t wr_lane_o,
  output lane_mask_t rd_lane_o
);
  logic sel;
  assign sel = ~cs_ni;

  always_comb begin
    for (int l = 0; l < int'(LANES); l++) begin
      wr_lane_o[l] = sel & ~we_ni & ~be_ni[l];
      rd_lane_o[l] = sel & we_ni & ~oe_ni & ~be_ni[l];
    end
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_act_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [BYTE_W-1:0] dout_o
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] din_q;
  logic              commit;

  // overlap ended: store what was present in its last cycle
  assign commit = act_q & ~wr_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      act_q  <= wr_act_i;
      addr_q <= addr_i;
      din_q  <= din_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit) mem[addr_q] <= din_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      dout_o <= '0;
    end else begin
      if (commit) vld_q[addr_q] <= 1'b1;
      dout_o <= vld_q[addr_i] ? mem[addr_i] : '0;
    end
  end
endmodule

// File: rtl/sram_drive_gate.sv
module sram_drive_gate
  import sram_pkg::*;
#(
  parameter int unsigned TURN_ON = 2,
  localparam int unsigned CNT_W = $clog2(TURN_ON + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_ni,
  input  lane_mask_t rd_lane_i,
  output lane_mask_t lane_oe_o
);
  logic [CNT_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= CNT_W'(TURN_ON);
      lane_oe_o <= '0;
    end else begin
      if (!we_ni)              hold_q <= CNT_W'(TURN_ON);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      lane_oe_o <= (hold_q == '0) ? rd_lane_i : '0;
    end
  end
endmodule

// File: rtl/sram_bytelane.sv
module sram_bytelane
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned TURN_ON = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              ub_ni,
  input  logic              lb_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  lane_oe_o
);
  lane_mask_t wr_lane, rd_lane;

  sram_decode u_dec (
    .cs_ni     (cs_ni),
    .we_ni     (we_ni),
    .oe_ni     (oe_ni),
    .be_ni     ({ub_ni, lb_ni}),
    .wr_lane_o (wr_lane),
    .rd_lane_o (rd_lane)
  );

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (addr_i),
      .wr_act_i (wr_lane[l]),
      .din_i    (data_i[l*BYTE_W +: BYTE_W]),
      .dout_o   (data_o[l*BYTE_W +: BYTE_W])
    );
  end

  sram_drive_gate #(.TURN_ON(TURN_ON)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_ni     (we_ni),
    .rd_lane_i (rd_lane),
    .lane_oe_o (lane_oe_o)
  );
endmodule

// File: rtl/sram_bytelane_chk.sv
module sram_bytelane_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       we_ni,
  input logic       oe_ni,
  input logic       ub_ni,
  input logic       lb_ni,
  input logic [1:0] lane_oe_o
);
  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> lane_oe_o == 2'b00); // R2

  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> lane_oe_o == 2'b00); // R7

  AST_TURN_ON_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_ni) |=> lane_oe_o == 2'b00); // R7

  AST_LOW_LANE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_oe_o[0] |-> (!$past(lb_ni) && !$past(oe_ni) && !$past(cs_ni) && $past(we_ni))); // R3

  AST_HIGH_LANE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_oe_o[1] |-> (!$past(ub_ni) && !$past(oe_ni) && !$past(cs_ni) && $past(we_ni))); // R6
endmodule

bind sram_bytelane sram_bytelane_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .we_ni     (we_ni),
  .oe_ni     (oe_ni),
  .ub_ni     (ub_ni),
  .lb_ni     (lb_ni),
  .lane_oe_o (lane_oe_o)
);

// File: tb/tb_sram_bytelane.sv
module tb_sram_bytelane;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [15:0]   din = '0;
  logic [15:0]   dout;
  logic [1:0]    loe;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  sram_bytelane #(.ADDR_W(AW), .TURN_ON(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .cs_ni(cs_n), .we_ni(we_n),
    .oe_ni(oe_n), .ub_ni(ub_n), .lb_ni(lb_n), .data_i(din), .data_o(dout),
    .lane_oe_o(loe)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
  endtask

  // be = {ub_n, lb_n}
  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; {ub_n, lb_n} = be; addr = a; din = d;
    tick();
    chk("R7 drivers off in write", {14'd0, loe}, 16'd0);
    @(negedge clk);
    we_n = 1'b1; cs_n = 1'b1;
    tick();
    idle();
  endtask

  task automatic do_read(string tag, logic [AW-1:0] a, logic oen, logic [1:0] be,
                         logic [1:0] exp_oe, logic [15:0] exp_d, logic [15:0] msk);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b1; oe_n = oen; {ub_n, lb_n} = be; addr = a;
    repeat (3) tick();
    chk({tag, " lane enables"}, {14'd0, loe}, {14'd0, exp_oe});
    chk({tag, " data"}, dout & msk, exp_d & msk);
    idle();
  endtask

  task automatic t_reset();
    chk("R8 reset enables", {14'd0, loe}, 16'd0);
    chk("R8 reset data", dout, 16'd0);
  endtask

  task automatic t_unwritten();
    do_read("R1 unwritten", 10'd5, 1'b0, 2'b00, 2'b11, 16'h0000, 16'hFFFF);
  endtask

  task automatic t_lane_writes();
    do_write(10'd3, 16'h1234, 2'b00);
    do_read("R4 word write", 10'd3, 1'b0, 2'b00, 2'b11, 16'h1234, 16'hFFFF);
    do_write(10'd3, 16'hFFAB, 2'b10);
    do_read("R4 low-lane write", 10'd3, 1'b0, 2'b00, 2'b11, 16'h12AB, 16'hFFFF);
    do_write(10'd3, 16'hCDEE, 2'b01);
    do_read("R4 high-lane write", 10'd3, 1'b0, 2'b00, 2'b11, 16'hCDAB, 16'hFFFF);
    do_write(10'd3, 16'h7777, 2'b11);
    do_read("R4 no-lane write", 10'd3, 1'b0, 2'b00, 2'b11, 16'hCDAB, 16'hFFFF);
  endtask

  task automatic t_lane_reads();
    do_read("R3 low lane read", 10'd3, 1'b0, 2'b10, 2'b01, 16'h00AB, 16'h00FF);
    do_read("R3 high lane read", 10'd3, 1'b0, 2'b01, 2'b10, 16'hCD00, 16'hFF00);
    do_read("R6 output enable high", 10'd3, 1'b1, 2'b00, 2'b00, 16'hCDAB, 16'hFFFF);
    do_read("R6 both bytes off", 10'd3, 1'b0, 2'b11, 2'b00, 16'hCDAB, 16'hFFFF);
  endtask

  task automatic t_deselect();
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
    addr = 10'd3; din = 16'h0F0F;
    repeat (2) tick();
    chk("R2 deselect enables", {14'd0, loe}, 16'd0);
    idle();
    do_read("R2 deselect no write", 10'd3, 1'b0, 2'b00, 2'b11, 16'hCDAB, 16'hFFFF);
  endtask

  task automatic t_last_cycle();
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
    addr = 10'd7; din = 16'h1111;
    tick();
    @(negedge clk); din = 16'h2222;
    tick();
    @(negedge clk); cs_n = 1'b1; din = 16'h3333;  // chip select ends overlap
    tick();
    chk("R5 quiet during write", {14'd0, loe}, 16'd0);
    idle();
    do_read("R5 last overlap data", 10'd7, 1'b0, 2'b00, 2'b11, 16'h2222, 16'hFFFF);
  endtask

  task automatic t_turn_on();
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
    addr = 10'd9; din = 16'h5A5A;
    tick();
    @(negedge clk); we_n = 1'b1;
    tick();
    chk("R7 hold-off edge 1", {14'd0, loe}, 16'd0);
    tick();
    chk("R7 hold-off edge 2", {14'd0, loe}, 16'd0);
    tick();
    chk("R7 drivers back on", {14'd0, loe}, 16'h0003);
    chk("R7 written data", dout, 16'h5A5A);
    idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) tick();
    t_unwritten();
    t_lane_writes();
    t_lane_reads();
    t_deselect();
    t_last_cycle();
    t_turn_on();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule